// File: doc/BRIEF.md
# Gated-Enable Bus Register

This block is a parallel-load storage register that sits on a shared data bus. On a rising clock edge it captures the data word, but only when both of its active-low load enables are low. In every other case it keeps its present contents. An active-high clear input zeroes the stored word at once. The clear does not wait for a clock edge, and it overrides the clock, the load enables and the output enables.

The stored word reaches the bus through per-bit tristate drivers. The register drives the bus only while both active-low output enables are low. When either one is high, it releases the bus so that another agent can drive it. Releasing the bus changes neither the stored word nor the way the register loads and holds. A second, always-driven copy of the stored word is provided so that the contents can be observed while the bus is released. The word width is a parameter with a default of 4, and it applies to the data input, the stored state and both outputs.

Top module: `bus_hold_reg`

## Requirements
- R1: The stored word changes only on a low-to-high clock transition or through the clear. A change on the data input while the clock is steady leaves `qPlain` unchanged.
- R2: At a rising clock edge with `clearIn` low and both `loadEnA_n` and `loadEnB_n` low, every stored bit takes the value of the matching `dIn` bit.
- R3: At a rising clock edge with `clearIn` low and either `loadEnA_n` or `loadEnB_n` high, the stored word keeps its previous value. This holds for each of the three such combinations.
- R4: While `clearIn` is high, the stored word is 0 without any clock edge. This is true whatever the values of the load enables, the output enables and the data input.
- R5: When `clearIn` falls between clock edges, the stored word stays 0 until the next rising edge at which both load enables are low.
- R6: While both `outEnA_n` and `outEnB_n` are low, `qBus` carries the stored word.
- R7: While either `outEnA_n` or `outEnB_n` is high, every bit of `qBus` is released to high impedance, so a value driven onto the bus by another agent is read back unchanged.
- R8: Releasing the bus has no effect on the stored word or on loading. A load made while the bus is released appears on `qPlain` at once and on `qBus` when the bus is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register acts on rising edges |
| clearIn | input | 1 | Asynchronous clear, active high, overrides all other inputs |
| dIn | input | WIDTH | Data word to be captured |
| loadEnA_n | input | 1 | First load enable, active low |
| loadEnB_n | input | 1 | Second load enable, active low |
| outEnA_n | input | 1 | First bus output enable, active low |
| outEnB_n | input | 1 | Second bus output enable, active low |
| qBus | output | WIDTH | Tristate bus output carrying the stored word |
| qPlain | output | WIDTH | Always-driven copy of the stored word |

## Verification
The hardest situation to reach is a released bus, because high impedance cannot be seen directly when the simulator is two-state. The bench therefore acts as a second bus agent. Whenever the register's output enables should release the bus, the bench drives the complement of the stored word onto the bus and expects to read that complement back. Any leftover drive from the register would corrupt that value. The second hard case is a clear released between clock edges. The bench pulses the clear in mid-cycle and holds the load enables high across the following edge, which shows that the zero persists until an enabled edge arrives.

// File: rtl/bus_hold_reg_pkg.sv
package bus_hold_reg_pkg;

  // Strobes passed from the enable decoder to the datapath
  typedef struct packed {
    logic loadEn;   // capture dIn at the next rising edge
    logic driveEn;  // drive the stored word onto the bus
  } regStrobes_t;

endpackage

// File: rtl/bus_hold_reg_ctrl.sv
module bus_hold_reg_ctrl
  import bus_hold_reg_pkg::*;
(
  input  logic        loadEnA_n,
  input  logic        loadEnB_n,
  input  logic        outEnA_n,
  input  logic        outEnB_n,
  output regStrobes_t strobes
);

  // Loading needs both active-low enables; any high disable releases the bus
  always_comb begin
    strobes.loadEn  = ~(loadEnA_n | loadEnB_n);
    strobes.driveEn = ~(outEnA_n | outEnB_n);
  end

endmodule

// File: rtl/bus_hold_reg_dp.sv
module bus_hold_reg_dp
  import bus_hold_reg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearIn,
  input  logic [WIDTH-1:0] dIn,
  input  regStrobes_t      strobes,
  output logic [WIDTH-1:0] qBus,
  output logic [WIDTH-1:0] qPlain
);

  localparam logic [WIDTH-1:0] ZERO_WORD = '0;

  logic [WIDTH-1:0] stored;

  always_ff @(posedge clk or posedge clearIn) begin
    if (clearIn) begin
      stored <= ZERO_WORD;
    end else if (strobes.loadEn) begin
      stored <= dIn;
    end
  end

  assign qPlain = stored;

  // One tristate driver per bit
  for (genvar g = 0; g < WIDTH; g++) begin : gen_drv
    assign qBus[g] = strobes.driveEn ? stored[g] : 1'bz;
  end

endmodule

// File: rtl/bus_hold_reg.sv
module bus_hold_reg
  import bus_hold_reg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearIn,
  input  logic [WIDTH-1:0] dIn,
  input  logic             loadEnA_n,
  input  logic             loadEnB_n,
  input  logic             outEnA_n,
  input  logic             outEnB_n,
  output logic [WIDTH-1:0] qBus,
  output logic [WIDTH-1:0] qPlain
);

  regStrobes_t strobes;

  bus_hold_reg_ctrl ctrl_i (
    .loadEnA_n (loadEnA_n),
    .loadEnB_n (loadEnB_n),
    .outEnA_n  (outEnA_n),
    .outEnB_n  (outEnB_n),
    .strobes   (strobes)
  );

  bus_hold_reg_dp #(.WIDTH(WIDTH)) dp_i (
    .clk     (clk),
    .clearIn (clearIn),
    .dIn     (dIn),
    .strobes (strobes),
    .qBus    (qBus),
    .qPlain  (qPlain)
  );

endmodule

// File: rtl/bus_hold_reg_chk.sv
module bus_hold_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clearIn,
  input logic [WIDTH-1:0] dIn,
  input logic             loadEnA_n,
  input logic             loadEnB_n,
  input logic             outEnA_n,
  input logic             outEnB_n,
  input logic [WIDTH-1:0] qBus,
  input logic [WIDTH-1:0] qPlain
);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (clearIn)
    (!loadEnA_n && !loadEnB_n) |=> (qPlain == $past(dIn)));

  // R3
  hold_when_disabled_chk: assert property (@(posedge clk) disable iff (clearIn)
    (loadEnA_n || loadEnB_n) |=> $stable(qPlain));

  // R4
  clear_zero_chk: assert property (@(posedge clk)
    clearIn |-> (qPlain == '0));

  // R6
  bus_drive_chk: assert property (@(posedge clk) disable iff (clearIn)
    (!outEnA_n && !outEnB_n) |-> (qBus == qPlain));

endmodule

bind bus_hold_reg bus_hold_reg_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .clearIn   (clearIn),
  .dIn       (dIn),
  .loadEnA_n (loadEnA_n),
  .loadEnB_n (loadEnB_n),
  .outEnA_n  (outEnA_n),
  .outEnB_n  (outEnB_n),
  .qBus      (qBus),
  .qPlain    (qPlain)
);

// File: tb/bus_hold_reg_tb_top.sv
`timescale 1ns/1ps
module bus_hold_reg_tb_top;

  localparam int W = 4;

  typedef struct packed {
    logic [W-1:0] d;
    logic         ia;
    logic         ib;
    logic         oa;
    logic         ob;
    logic [W-1:0] expQ;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{4'h5, 1'b0, 1'b0, 1'b0, 1'b0, 4'h5},
    '{4'hA, 1'b1, 1'b0, 1'b0, 1'b0, 4'h5},
    '{4'hA, 1'b0, 1'b1, 1'b0, 1'b0, 4'h5},
    '{4'hA, 1'b1, 1'b1, 1'b0, 1'b0, 4'h5},
    '{4'hA, 1'b0, 1'b0, 1'b1, 1'b0, 4'hA},
    '{4'h3, 1'b0, 1'b0, 1'b0, 1'b1, 4'h3},
    '{4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF},
    '{4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF},
    '{4'h9, 1'b0, 1'b0, 1'b0, 1'b0, 4'h9},
    '{4'h6, 1'b0, 1'b1, 1'b0, 1'b0, 4'h9}
  };

  logic         clk = 1'b0;
  logic         clearIn = 1'b1;
  logic [W-1:0] dIn = '0;
  logic         loadEnA_n = 1'b1;
  logic         loadEnB_n = 1'b1;
  logic         outEnA_n = 1'b0;
  logic         outEnB_n = 1'b0;
  logic         tbDrive = 1'b0;
  logic [W-1:0] tbVal = '0;
  wire  [W-1:0] qBus;
  logic [W-1:0] qPlain;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // Second bus agent
  assign qBus = tbDrive ? tbVal : 'z;

  bus_hold_reg #(.WIDTH(W)) dut_i (
    .clk       (clk),
    .clearIn   (clearIn),
    .dIn       (dIn),
    .loadEnA_n (loadEnA_n),
    .loadEnB_n (loadEnB_n),
    .outEnA_n  (outEnA_n),
    .outEnB_n  (outEnB_n),
    .qBus      (qBus),
    .qPlain    (qPlain)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    // Reset state: R4 clear holds word at zero, R6 bus shows it
    repeat (3) @(posedge clk);
    #1;
    check("R4 reset state plain", qPlain, '0);
    check("R6 reset state bus", qBus, '0);
    @(negedge clk);
    clearIn = 1'b0;

    // Vector table: R2, R3, R6, R7, R8
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      dIn = VECS[i].d;
      loadEnA_n = VECS[i].ia;
      loadEnB_n = VECS[i].ib;
      outEnA_n = VECS[i].oa;
      outEnB_n = VECS[i].ob;
      tbDrive = VECS[i].oa | VECS[i].ob;
      tbVal = ~VECS[i].expQ;
      @(posedge clk);
      #1;
      check((VECS[i].ia | VECS[i].ib) ? "R3 hold" : "R2 load", qPlain, VECS[i].expQ);
      if (tbDrive)
        check("R7 bus released (R8 contents kept)", qBus, ~VECS[i].expQ);
      else
        check("R6 bus drives word", qBus, VECS[i].expQ);
    end

    // R8: word loaded while the bus was released shows once it is enabled again
    @(negedge clk);
    loadEnA_n = 1'b0; loadEnB_n = 1'b0; dIn = 4'hC;
    outEnA_n = 1'b1; outEnB_n = 1'b0; tbDrive = 1'b1; tbVal = 4'h1;
    @(posedge clk); #1;
    check("R8 load while released", qPlain, 4'hC);
    check("R7 bus released", qBus, 4'h1);
    @(negedge clk);
    loadEnA_n = 1'b1;
    tbDrive = 1'b0; outEnA_n = 1'b0;
    #0.5;
    check("R8 bus after re-enable", qBus, 4'hC);

    // R1: data change with steady clock does nothing
    @(posedge clk); #1;
    loadEnA_n = 1'b0; loadEnB_n = 1'b0; dIn = 4'h7;
    #1;
    check("R1 no change mid-cycle", qPlain, 4'hC);
    @(posedge clk); #1;
    check("R1 change at rising edge", qPlain, 4'h7);
    @(negedge clk);
    loadEnA_n = 1'b1;

    // R4: clear between edges, no clock edge needed
    @(posedge clk); #1;
    clearIn = 1'b1;
    #0.5;
    check("R4 async clear plain", qPlain, '0);
    check("R4 async clear bus", qBus, '0);
    @(negedge clk);
    loadEnA_n = 1'b0; dIn = 4'hF;
    @(posedge clk); #1;
    check("R4 clear beats enabled edge", qPlain, '0);

    // R5: release clear mid-cycle, stays zero until an enabled edge
    @(negedge clk);
    loadEnA_n = 1'b1;
    clearIn = 1'b0;
    #0.5;
    check("R5 zero after mid-cycle release", qPlain, '0);
    @(posedge clk); #1;
    check("R5 zero across disabled edge", qPlain, '0);
    @(negedge clk);
    loadEnA_n = 1'b0; dIn = 4'hB;
    @(posedge clk); #1;
    check("R5 load on next enabled edge", qPlain, 4'hB);

    done = 1'b1;
    finish_run();
  end

endmodule